// File: doc/BRIEF.md
# Programmable Interval Timer with Reload

A 16-bit down-counting interval timer for a small processor subsystem. Software programs a modulus and a control word through a single-cycle register port. The counter then counts down once per tick. A tick is either every clock or every 64th clock. When the count reaches zero, the timer sets a sticky interrupt flag. A level interrupt is raised while that flag and the interrupt enable are both set.

The same counter serves two uses, and two independent control bits select between them. The reload bit gives periodic ticks: the count is refilled from the modulus after it has passed through zero. The overwrite bit makes a modulus write load the counter at once, so in one-shot mode each modulus write starts a fresh delay. Software reads the live count at any time, so elapsed ticks in a period are the modulus minus the count. Writing 1 to the flag position of the control word acknowledges the interrupt.

Register map (`bus_addr`): 0 is control, 1 is modulus, 2 is the current count (read-only), and 3 reads as zero. Control bits: [0] run, [1] reload, [2] flag (write 1 to clear), [3] interrupt enable, [4] overwrite, [5] divide-by-64.

Top module: `prog_interval_timer`

## Requirements
- R1: Reset clears every control bit and the flag, sets modulus and count to 0xFFFF, and holds `irq` low.
- R2: A control write that sets the run bit while the timer is stopped loads the count from the modulus. After that, each tick lowers the count by one, and the count register (address 2) returns the live value.
- R3: A tick that takes the count from 1 to 0 sets the flag. `irq` is high exactly when the flag and the interrupt-enable bit (bit 3) are both set.
- R4: The flag stays set until a control write with bit 2 = 1 clears it. Other control writes leave it set. If expiry and a clearing write fall in the same cycle, the flag stays set.
- R5: With reload (bit 1) set, a tick at count 0 loads the modulus without setting the flag. The period is therefore modulus + 1 ticks.
- R6: With reload clear, the count stays at 0 after expiry until the counter is loaded again.
- R7: With overwrite (bit 4) set, a modulus write loads the count in the same cycle. This load takes priority over a tick and does not cause an expiry. With overwrite clear, a modulus write leaves the count unchanged.
- R8: With bit 5 set, a tick occurs once every 64 clocks, and the first tick comes 64 clocks after the run bit is set. With bit 5 clear, every clock is a tick.
- R9: While the run bit is clear, the count does not change except through an overwrite load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read otherwise |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The counter is exercised in periodic and one-shot configurations, at full clock rate and with the divide-by-64 prescaler. Counts are sampled just before, at and after expiry, which separates an off-by-one period from a missing reload or a missing hold at zero. Modulus writes are issued with overwrite both on and off, and with the timer both stopped and running. This shows whether a load happens at all, and whether it wins over a tick at count 1. Flag clearing is tried with the mask bit low and with an expiry in the same cycle, so a flag set by expiry is told apart from the output gate that drives `irq`.

// File: rtl/prog_interval_timer.sv
module prog_interval_timer #(
  parameter int CNT_W    = 16,
  parameter int DIV_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONES = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic en, rld, ie, ovw, slow, flag;
  logic [CNT_W-1:0]    modulus, count;
  logic [DIV_LOG2-1:0] pre;

  wire ctl_wr  = bus_sel & bus_we & (bus_addr == 2'd0);
  wire mod_wr  = bus_sel & bus_we & (bus_addr == 2'd1);
  wire ow_load = mod_wr & ovw;
  wire en_rise = ctl_wr & bus_wdata[0] & ~en;
  wire tick    = en & (~slow | (&pre));
  wire expire  = tick & (count == ONE) & ~ow_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {en, rld, ie, ovw, slow} <= '0;
    end else if (ctl_wr) begin
      en   <= bus_wdata[0];
      rld  <= bus_wdata[1];
      ie   <= bus_wdata[3];
      ovw  <= bus_wdata[4];
      slow <= bus_wdata[5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      flag <= 1'b0;
    else if (expire)                 flag <= 1'b1;
    else if (ctl_wr && bus_wdata[2]) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       modulus <= ONES;
    else if (mod_wr)  modulus <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) pre <= '0;
    else if (slow)     pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              count <= ONES;
    else if (ow_load)        count <= bus_wdata;
    else if (en_rise)        count <= modulus;
    else if (tick) begin
      if (count != '0)       count <= count - 1'b1;
      else if (rld)          count <= modulus;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = CNT_W'({slow, ovw, ie, flag, rld, en});
      2'd1:    bus_rdata = modulus;
      2'd2:    bus_rdata = count;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = flag & ie;
endmodule

module prog_interval_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             rld,
  input logic             flag,
  input logic             tick,
  input logic             ow_load,
  input logic             en_rise,
  input logic             ctl_wr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [CNT_W-1:0] count
);
  a_r9_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ow_load && !en_rise) |=> $stable(count));

  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != '0 && !ow_load) |=> count == $past(count) - 1'b1);

  a_r3_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !ow_load && tick && count == CNT_W'(1)) |=> flag);

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(ctl_wr && bus_wdata[2])) |=> flag);

  a_r6_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rld && count == '0 && !ow_load && !ctl_wr) |=> count == '0);
endmodule

bind prog_interval_timer prog_interval_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .rld(rld), .flag(flag), .tick(tick),
  .ow_load(ow_load), .en_rise(en_rise), .ctl_wr(ctl_wr),
  .bus_wdata(bus_wdata), .count(count)
);

// File: tb/tb_prog_interval_timer.sv
`timescale 1ns/1ps
module tb_prog_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  prog_interval_timer dut (.*);

  always #10 clk = ~clk;

  localparam logic [1:0] WR = 2'd0, WT = 2'd1, RD = 2'd2, IQ = 2'd3;
  localparam int NV = 70;
  // {req, op, addr, data}
  localparam logic [23:0] VEC [NV] = '{
    {4'd1, RD, 2'd0, 16'h0000},   // R1
    {4'd1, RD, 2'd1, 16'hFFFF},   // R1
    {4'd1, RD, 2'd2, 16'hFFFF},   // R1
    {4'd1, IQ, 2'd0, 16'h0000},   // R1
    {4'd7, WR, 2'd1, 16'h0005},   // R7 no overwrite
    {4'd7, RD, 2'd2, 16'hFFFF},   // R7
    {4'd7, RD, 2'd1, 16'h0005},   // R7
    {4'd2, WR, 2'd0, 16'h000B},   // R2 run+reload+ie
    {4'd2, RD, 2'd2, 16'h0005},   // R2
    {4'd2, WT, 2'd0, 16'd2},
    {4'd2, RD, 2'd2, 16'h0003},   // R2
    {4'd2, WT, 2'd0, 16'd2},
    {4'd3, IQ, 2'd0, 16'h0000},   // R3 count 1
    {4'd3, WT, 2'd0, 16'd1},
    {4'd3, RD, 2'd2, 16'h0000},   // R3
    {4'd3, IQ, 2'd0, 16'h0001},   // R3
    {4'd3, RD, 2'd0, 16'h000F},   // R3
    {4'd5, WT, 2'd0, 16'd1},
    {4'd5, RD, 2'd2, 16'h0005},   // R5 reload
    {4'd4, IQ, 2'd0, 16'h0001},   // R4 sticky
    {4'd4, WR, 2'd0, 16'h000F},   // R4 clear
    {4'd4, IQ, 2'd0, 16'h0000},   // R4
    {4'd4, RD, 2'd0, 16'h000B},   // R4
    {4'd2, RD, 2'd2, 16'h0004},   // R2
    {4'd3, WR, 2'd0, 16'h0003},   // R3 mask off
    {4'd3, WT, 2'd0, 16'd3},
    {4'd3, IQ, 2'd0, 16'h0000},   // R3 masked
    {4'd3, RD, 2'd0, 16'h0007},   // R3 flag set
    {4'd9, WR, 2'd0, 16'h0004},   // R9 stop
    {4'd9, RD, 2'd0, 16'h0000},   // R9
    {4'd9, WT, 2'd0, 16'd10},
    {4'd9, RD, 2'd2, 16'h0005},   // R9 frozen
    {4'd7, WR, 2'd1, 16'h0003},   // R7
    {4'd7, RD, 2'd2, 16'h0005},   // R7
    {4'd6, WR, 2'd0, 16'h0019},   // R6 one-shot, ovw
    {4'd6, WT, 2'd0, 16'd3},
    {4'd6, WT, 2'd0, 16'd5},
    {4'd6, RD, 2'd2, 16'h0000},   // R6 hold
    {4'd6, IQ, 2'd0, 16'h0001},   // R6
    {4'd4, WR, 2'd0, 16'h001D},   // R4 clear
    {4'd4, IQ, 2'd0, 16'h0000},   // R4
    {4'd7, WR, 2'd1, 16'h0002},   // R7 restart
    {4'd7, RD, 2'd2, 16'h0002},   // R7
    {4'd6, WT, 2'd0, 16'd2},
    {4'd6, IQ, 2'd0, 16'h0001},   // R6
    {4'd6, RD, 2'd2, 16'h0000},   // R6
    {4'd8, WR, 2'd0, 16'h0004},   // R8 stop
    {4'd8, WR, 2'd1, 16'h0002},   // R8
    {4'd8, RD, 2'd2, 16'h0000},   // R8
    {4'd8, WR, 2'd0, 16'h0023},   // R8 div64
    {4'd8, WT, 2'd0, 16'd63},
    {4'd8, RD, 2'd2, 16'h0002},   // R8
    {4'd8, WT, 2'd0, 16'd1},
    {4'd8, RD, 2'd2, 16'h0001},   // R8
    {4'd8, WT, 2'd0, 16'd64},
    {4'd8, RD, 2'd0, 16'h0027},   // R8
    {4'd8, RD, 2'd2, 16'h0000},   // R8
    {4'd7, WR, 2'd0, 16'h0004},   // R7
    {4'd7, WR, 2'd0, 16'h0013},   // R7 run+reload+ovw
    {4'd7, WT, 2'd0, 16'd1},
    {4'd7, WR, 2'd1, 16'h0009},   // R7 load at count 1
    {4'd7, WT, 2'd0, 16'd1},
    {4'd7, RD, 2'd2, 16'h0008},   // R7
    {4'd5, WT, 2'd0, 16'd8},
    {4'd5, RD, 2'd2, 16'h0000},   // R5
    {4'd5, WT, 2'd0, 16'd1},
    {4'd5, RD, 2'd2, 16'h0009},   // R5 new modulus
    {4'd7, WR, 2'd0, 16'h0004},   // R7
    {4'd7, WR, 2'd1, 16'hFFFF},   // R7 max modulus
    {4'd7, RD, 2'd1, 16'hFFFF}    // R7
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic cmp(input int req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(input int req, input logic [1:0] a, input logic [15:0] e);
    bus_addr = a;
    #1 cmp(req, bus_rdata, e);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][19:18])
        WR: wr(VEC[i][17:16], VEC[i][15:0]);
        WT: repeat (int'(VEC[i][15:0])) @(negedge clk);
        RD: rd_chk(int'(VEC[i][23:20]), VEC[i][17:16], VEC[i][15:0]);
        default: cmp(int'(VEC[i][23:20]), {15'd0, irq}, VEC[i][15:0]);
      endcase
    end
    // R4: expiry and clearing write in the same cycle, the flag stays set
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h000B);
    rd_chk(4, 2'd2, 16'h0001);
    wr(2'd0, 16'h000F);
    cmp(4, {15'd0, irq}, 16'h0001);
    rd_chk(4, 2'd0, 16'h000F);
    // R1: reset in the middle of a run
    wr(2'd0, 16'h0003);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd_chk(1, 2'd0, 16'h0000);
    rd_chk(1, 2'd2, 16'hFFFF);
    rd_chk(1, 2'd1, 16'hFFFF);
    cmp(1, {15'd0, irq}, 16'h0000);
    summary();
    $finish;
  end
endmodule